// File: doc/BRIEF.md
# Paged Serial Flash Single-Byte Update Sequencer

This block changes one byte of a page-organised serial flash in place, without an erase step driven by the user. A caller presents a 12-bit page number, a byte offset inside that page and the new data byte, then pulses `start`. The sequencer runs a read-modify-write through the flash's internal page buffer. First the page is copied into buffer 1. Then the one byte is overwritten in the buffer. Finally the buffer is programmed back to the page, and the flash erases the page as part of that step.

On the flash side the block drives an active-low chip select and a mode-0 serial byte shifter, MSB first. Each status read learns the page geometry: 528 bytes with a 10-bit offset field, or 512 bytes with a 9-bit offset field. The block polls that status for readiness before every command and once more after the final program step. The user side is plain control: `start` is sampled only while `busy` is low. `busy` covers the whole operation. A one-cycle `done` pulse ends it, with `err` giving the outcome. There is no streaming interface, so no back-pressure applies.

Top module: `flash_byte_update`

## Requirements
- R1: A `start` pulse seen while `busy` is low latches page, offset and data, and `busy` is high from the next cycle; a `start` pulse while `busy` is high is ignored and changes nothing in the flash.
- R2: The first chip-select window of every operation is a two-byte status read (opcode D7 hex, then one dummy byte); bit 0 of the returned byte set to 1 selects 512-byte pages and set to 0 selects 528-byte pages.
- R3: An offset above 20F hex in 528-byte mode, or above 1FF hex in 512-byte mode, ends the operation after that first status read with `done` and `err` both high; `err` holds until the next accepted `start`.
- R4: Before each of the three update commands, and after the last one, a status read (D7 hex, two bytes) is repeated until bit 7 of the returned byte is 1; in total an operation issues 2p+5 status reads when the flash reports p busy polls after each of the copy and program commands.
- R5: The update commands go out in the order 53 hex (4 bytes), 84 hex (5 bytes), 83 hex (4 bytes), each in its own chip-select window.
- R6: For 53 hex and 83 hex the 24-bit address (sent MSB byte first) is the page number shifted left by 10 in 528-byte mode or by 9 in 512-byte mode, with zero offset bits.
- R7: For 84 hex the 24-bit address is the byte offset zero-extended, and the fifth byte is the data byte; the target byte takes the new value and every other byte of the page keeps its old value.
- R8: `cs_n` stays low for the whole of each command, returns high for at least DIV/2 clocks between commands, is high whenever `busy` is low, and `sck` is low whenever `cs_n` is high.
- R9: Each bit takes DIV clocks (half low, half high); MOSI changes only while `sck` is low, and MISO is sampled in the clock just before `sck` rises.
- R10: `busy` falls in the same cycle that `done` pulses high for exactly one cycle after the final ready status; `err` is low after a successful update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an update (sampled while idle) |
| page_num | input | PAGE_W | Target page number |
| byte_off | input | OFF_W | Byte offset inside the page |
| wr_data | input | 8 | New byte value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| err | output | 1 | Offset rejected for the detected page size |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to flash |
| miso | input | 1 | Serial data from flash |
| cs_n | output | 1 | Active-low chip select |

## Verification
A wrong step register would show within one chip-select window as a wrong opcode or a wrong byte count, or as a poll skipped or repeated. A latched page-size bit in the wrong state would show in the very first address byte of the copy command. It would also show as a spurious or missing `err` at the end of the first status read. A fault in the shifter's bit counter or divider would show on the first byte as a misframed opcode or a bit period other than DIV. A sequencer that stalls in a poll leaves `busy` high with no `done`, and the per-operation timeout catches that.

// File: rtl/flash_upd_pkg.sv
package flash_upd_pkg;
  localparam int ADDR_W = 24;

  localparam logic [7:0] OP_STATUS  = 8'hD7;
  localparam logic [7:0] OP_TO_BUF  = 8'h53;
  localparam logic [7:0] OP_BUF_WR  = 8'h84;
  localparam logic [7:0] OP_PROGRAM = 8'h83;

  // Order matters: the sequencer advances by incrementing.
  typedef enum logic [2:0] {
    ST_MODE, ST_POLL_A, ST_COPY, ST_POLL_B,
    ST_WRITE, ST_POLL_C, ST_PROG, ST_POLL_D
  } step_e;

  typedef enum logic [1:0] {T_IDLE, T_SEND, T_WAIT, T_GAP} xfer_e;

  function automatic logic is_status(step_e s);
    return (s == ST_MODE) || (s == ST_POLL_A) || (s == ST_POLL_B) ||
           (s == ST_POLL_C) || (s == ST_POLL_D);
  endfunction
endpackage

// File: rtl/flash_addr_fmt.sv
module flash_addr_fmt
  import flash_upd_pkg::*;
#(
  parameter int PAGE_W     = 12,
  parameter int OFF_W      = 10,
  parameter int LONG_LAST  = 527,
  parameter int SHORT_LAST = 511
) (
  input  logic              pg512,
  input  logic [PAGE_W-1:0] page,
  input  logic [OFF_W-1:0]  off,
  output logic [ADDR_W-1:0] page_addr,
  output logic [ADDR_W-1:0] buf_addr,
  output logic              in_range
);
  logic [ADDR_W-1:0] pg_ext;

  assign pg_ext    = ADDR_W'(page);
  assign page_addr = pg512 ? (pg_ext << (OFF_W - 1)) : (pg_ext << OFF_W);
  assign buf_addr  = ADDR_W'(off);
  assign in_range  = pg512 ? (off <= OFF_W'(SHORT_LAST))
                           : (off <= OFF_W'(LONG_LAST));
endmodule

// File: rtl/flash_spi_shift.sv
module flash_spi_shift #(
  parameter int HALF = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic [7:0] rx,
  output logic       fin
);
  localparam int CW = $clog2(HALF + 1);

  logic          active;
  logic [CW-1:0] cnt;
  logic [2:0]    bitn;
  logic [7:0]    sreg;

  assign mosi = sreg[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      bitn   <= '0;
      sreg   <= '0;
      rx     <= '0;
      sck    <= 1'b0;
      fin    <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (!active) begin
        if (go) begin
          sreg   <= tx;
          active <= 1'b1;
          cnt    <= '0;
          bitn   <= '0;
          sck    <= 1'b0;
        end
      end else if (cnt != CW'(HALF - 1)) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        if (!sck) begin
          sck <= 1'b1;
          rx  <= {rx[6:0], miso};   // last clock before the rising edge
        end else begin
          sck <= 1'b0;
          if (bitn == 3'd7) begin
            active <= 1'b0;
            fin    <= 1'b1;
          end else begin
            bitn <= bitn + 1'b1;
            sreg <= {sreg[6:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/flash_byte_update.sv
module flash_byte_update
  import flash_upd_pkg::*;
#(
  parameter int DIV        = 28,
  parameter int PAGE_W     = 12,
  parameter int OFF_W      = 10,
  parameter int LONG_LAST  = 527,
  parameter int SHORT_LAST = 511
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PAGE_W-1:0] page_num,
  input  logic [OFF_W-1:0]  byte_off,
  input  logic [7:0]        wr_data,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_n
);
  localparam int HALF = DIV / 2;
  localparam int GW   = $clog2(HALF + 1);

  step_e             step;
  xfer_e             xs;
  logic [2:0]        idx, last_idx;
  logic [GW-1:0]     gcnt;
  logic [PAGE_W-1:0] page_q;
  logic [OFF_W-1:0]  off_q;
  logic [7:0]        data_q, rx_q, tx_byte, sh_rx, opcode;
  logic              pg512_q, pg_mode, sh_go, sh_fin, in_range;
  logic [ADDR_W-1:0] page_addr, buf_addr, addr_sel;

  // During the first status read the mode bit is still in rx_q.
  assign pg_mode = (step == ST_MODE) ? rx_q[0] : pg512_q;
  assign sh_go   = (xs == T_SEND);

  flash_addr_fmt #(
    .PAGE_W(PAGE_W), .OFF_W(OFF_W),
    .LONG_LAST(LONG_LAST), .SHORT_LAST(SHORT_LAST)
  ) addr_i (
    .pg512(pg_mode), .page(page_q), .off(off_q),
    .page_addr(page_addr), .buf_addr(buf_addr), .in_range(in_range)
  );

  always_comb begin
    addr_sel = (step == ST_WRITE) ? buf_addr : page_addr;
    case (step)
      ST_COPY:  opcode = OP_TO_BUF;
      ST_WRITE: opcode = OP_BUF_WR;
      ST_PROG:  opcode = OP_PROGRAM;
      default:  opcode = OP_STATUS;
    endcase
    if (is_status(step))       last_idx = 3'd1;
    else if (step == ST_WRITE) last_idx = 3'd4;
    else                       last_idx = 3'd3;
    if (idx == 3'd0)            tx_byte = opcode;
    else if (is_status(step))   tx_byte = 8'h00;
    else begin
      case (idx)
        3'd1:    tx_byte = addr_sel[23:16];
        3'd2:    tx_byte = addr_sel[15:8];
        3'd3:    tx_byte = addr_sel[7:0];
        default: tx_byte = data_q;
      endcase
    end
  end

  flash_spi_shift #(.HALF(HALF)) shift_i (
    .clk(clk), .rst_n(rst_n), .go(sh_go), .tx(tx_byte), .miso(miso),
    .sck(sck), .mosi(mosi), .rx(sh_rx), .fin(sh_fin)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xs      <= T_IDLE;
      step    <= ST_MODE;
      idx     <= '0;
      gcnt    <= '0;
      page_q  <= '0;
      off_q   <= '0;
      data_q  <= '0;
      rx_q    <= '0;
      pg512_q <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
      cs_n    <= 1'b1;
    end else begin
      done <= 1'b0;
      case (xs)
        T_IDLE: begin
          if (start) begin
            page_q <= page_num;
            off_q  <= byte_off;
            data_q <= wr_data;
            busy   <= 1'b1;
            err    <= 1'b0;
            step   <= ST_MODE;
            idx    <= '0;
            cs_n   <= 1'b0;
            xs     <= T_SEND;
          end
        end
        T_SEND: xs <= T_WAIT;
        T_WAIT: begin
          if (sh_fin) begin
            rx_q <= sh_rx;
            if (idx == last_idx) begin
              cs_n <= 1'b1;
              gcnt <= '0;
              xs   <= T_GAP;
            end else begin
              idx <= idx + 1'b1;
              xs  <= T_SEND;
            end
          end
        end
        default: begin
          if (gcnt != GW'(HALF - 1)) begin
            gcnt <= gcnt + 1'b1;
          end else begin
            idx  <= '0;
            cs_n <= 1'b0;
            xs   <= T_SEND;
            case (step)
              ST_MODE: begin
                pg512_q <= rx_q[0];
                if (!in_range) begin
                  xs   <= T_IDLE;
                  cs_n <= 1'b1;
                  busy <= 1'b0;
                  done <= 1'b1;
                  err  <= 1'b1;
                end else begin
                  step <= ST_POLL_A;
                end
              end
              ST_POLL_A, ST_POLL_B, ST_POLL_C:
                if (rx_q[7]) step <= step_e'(step + 3'd1);
              ST_POLL_D:
                if (rx_q[7]) begin
                  xs   <= T_IDLE;
                  cs_n <= 1'b1;
                  busy <= 1'b0;
                  done <= 1'b1;
                end
              default: step <= step_e'(step + 3'd1);
            endcase
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/flash_byte_update_chk.sv
module flash_byte_update_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic err,
  input logic sck,
  input logic mosi,
  input logic cs_n
);
  // R1
  busy_rise_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R3
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done);

  // R8
  sck_low_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  // R8
  select_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);

  // R9
  mosi_steady_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> $stable(mosi));

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind flash_byte_update flash_byte_update_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .err(err), .sck(sck), .mosi(mosi), .cs_n(cs_n)
);

// File: tb/flash_byte_update_tb.sv
module flash_byte_update_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [11:0] page_num = '0;
  logic [9:0]  byte_off = '0;
  logic [7:0]  wr_data = '0;
  logic        busy, done, err, sck, mosi, cs_n;
  logic        miso = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  flash_byte_update #(.DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .page_num(page_num),
    .byte_off(byte_off), .wr_data(wr_data), .busy(busy), .done(done),
    .err(err), .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  // ---------------- flash model ----------------
  logic [7:0] mem [int];
  logic [7:0] fbuf [0:527];
  logic       model_512 = 1'b0;
  int         busy_polls = 0;
  int         busy_left = 0;
  logic [7:0] rbytes [0:7];
  int         nbytes = 0;
  int         bitc = 0;
  logic [7:0] in_sr = '0;
  logic [7:0] out_sr = '0;
  int         op_l [0:63];
  int         len_l [0:63];
  int         addr_l [0:63];
  int         dat_l [0:63];
  int         nlog = 0;

  function automatic logic [7:0] rd(int pg, int off);
    int k = pg * 1024 + off;
    if (mem.exists(k)) return mem[k];
    return 8'hFF;
  endfunction

  always @(negedge cs_n) begin
    nbytes = 0;
    bitc   = 0;
  end

  always @(posedge sck) begin
    if (cs_n == 1'b0) begin
      in_sr = {in_sr[6:0], mosi};
      bitc++;
      if (bitc == 8) begin
        bitc = 0;
        if (nbytes < 8) rbytes[nbytes] = in_sr;
        nbytes++;
        if (nbytes == 1 && in_sr == 8'hD7)
          out_sr = {(busy_left == 0), 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, model_512};
        else
          out_sr = 8'h00;
      end
    end
  end

  always @(negedge sck) begin
    miso   <= out_sr[7];
    out_sr = {out_sr[6:0], 1'b0};
  end

  always @(posedge cs_n) begin
    if (nbytes > 0) begin
      int a, sh, pg, off, psz;
      a   = (nbytes >= 4) ? {8'h00, rbytes[1], rbytes[2], rbytes[3]} : 0;
      sh  = model_512 ? 9 : 10;
      psz = model_512 ? 512 : 528;
      pg  = a >> sh;
      off = a & ((1 << sh) - 1);
      if (nlog < 64) begin
        op_l[nlog]   = rbytes[0];
        len_l[nlog]  = nbytes;
        addr_l[nlog] = a;
        dat_l[nlog]  = (nbytes >= 5) ? rbytes[4] : -1;
        nlog++;
      end
      if (rbytes[0] == 8'hD7) begin
        if (busy_left > 0) busy_left--;
      end else if (rbytes[0] == 8'h53 && nbytes == 4) begin
        for (int i = 0; i < psz; i++) fbuf[i] = rd(pg, i);
        busy_left = busy_polls;
      end else if (rbytes[0] == 8'h84 && nbytes == 5) begin
        if (off < psz) fbuf[off] = rbytes[4];
      end else if (rbytes[0] == 8'h83 && nbytes == 4) begin
        for (int i = 0; i < psz; i++) mem[pg * 1024 + i] = fbuf[i];
        busy_left = busy_polls;
      end
    end
  end

  // ---------------- serial timing monitor ----------------
  logic sck_d = 1'b0, mosi_d = 1'b0;
  int   last_rise = 0, rib = 0, bad_period = 0, bad_mosi = 0, n_rise = 0;
  int   gap_len = 0, min_gap = 1000;
  logic cs_d = 1'b1;

  always @(negedge clk) begin
    if (sck && mosi !== mosi_d) bad_mosi++;
    if (cs_n) rib = 0;
    if (sck && !sck_d) begin
      n_rise++;
      if (rib != 0 && (cyc - last_rise) != DIV) bad_period++;
      rib = (rib + 1) % 8;
      last_rise = cyc;
    end
    if (busy && cs_n) gap_len++;
    if (!cs_n && cs_d && gap_len > 0 && gap_len < min_gap) min_gap = gap_len;
    if (!cs_n) gap_len = 0;
    sck_d  = sck;
    mosi_d = mosi;
    cs_d   = cs_n;
  end

  // ---------------- helpers ----------------
  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_log();
    nlog = 0;
  endtask

  task automatic pulse_start(input int pg, input int off, input int dat);
    @(negedge clk);
    page_num = pg[11:0];
    byte_off = off[9:0];
    wr_data  = dat[7:0];
    start    = 1'b1;
    @(negedge clk);
    start    = 1'b0;
  endtask

  task automatic wait_done(output logic seen);
    seen = 1'b0;
    for (int i = 0; i < 40000 && !seen; i++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
    chk(seen, "R10", "done seen", seen, 1);
  endtask

  task automatic fill_page(input int pg, input int psz);
    for (int i = 0; i < psz; i++) mem[pg * 1024 + i] = 8'(i) ^ 8'h5A;
  endtask

  task automatic check_sequence(input string tag, input int pg, input int off,
                                input int dat, input logic m512, input int polls);
    int n_st = 0, n_cmd = 0;
    int exp_pa = pg << (m512 ? 9 : 10);
    int ops [0:2];
    int lens [0:2];
    int adrs [0:2];
    int dats [0:2];
    for (int i = 0; i < nlog; i++) begin
      if (op_l[i] == 8'hD7) begin
        n_st++;
        chk(len_l[i] == 2, "R4", {tag, " status length"}, len_l[i], 2);
      end else if (n_cmd < 3) begin
        ops[n_cmd]  = op_l[i];
        lens[n_cmd] = len_l[i];
        adrs[n_cmd] = addr_l[i];
        dats[n_cmd] = dat_l[i];
        n_cmd++;
      end else n_cmd++;
    end
    chk(op_l[0] == 8'hD7, "R2", {tag, " first window is status"}, op_l[0], 8'hD7);
    chk(n_st == 2 * polls + 5, "R4", {tag, " status reads"}, n_st, 2 * polls + 5);
    chk(n_cmd == 3, "R5", {tag, " command count"}, n_cmd, 3);
    if (n_cmd == 3) begin
      chk(ops[0] == 8'h53 && lens[0] == 4, "R5", {tag, " first cmd"}, ops[0], 8'h53);
      chk(ops[1] == 8'h84 && lens[1] == 5, "R5", {tag, " second cmd"}, ops[1], 8'h84);
      chk(ops[2] == 8'h83 && lens[2] == 4, "R5", {tag, " third cmd"}, ops[2], 8'h83);
      chk(adrs[0] == exp_pa, "R6", {tag, " copy address"}, adrs[0], exp_pa);
      chk(adrs[2] == exp_pa, "R6", {tag, " program address"}, adrs[2], exp_pa);
      chk(adrs[1] == off, "R7", {tag, " buffer address"}, adrs[1], off);
      chk(dats[1] == dat, "R7", {tag, " data byte"}, dats[1], dat);
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk(busy == 1'b0, "R10", "reset busy", busy, 0);
    chk(done == 1'b0, "R10", "reset done", done, 0);
    chk(err == 1'b0, "R3", "reset err", err, 0);
    chk(cs_n == 1'b1, "R8", "reset cs_n", cs_n, 1);
    chk(sck == 1'b0, "R8", "reset sck", sck, 0);
  endtask

  task automatic t_update_528();
    logic seen;
    model_512 = 1'b0; busy_polls = 2; clear_log();
    fill_page(12'h286, 528);
    pulse_start(12'h286, 10'h1EB, 8'h42);
    chk(busy == 1'b1, "R1", "busy after start", busy, 1);
    wait_done(seen);
    chk(busy == 1'b0, "R10", "busy falls with done", busy, 0);
    chk(err == 1'b0, "R10", "err after success", err, 0);
    @(negedge clk);
    chk(done == 1'b0, "R10", "done one cycle", done, 0);
    check_sequence("528", 12'h286, 10'h1EB, 8'h42, 1'b0, 2);
    chk(rd(12'h286, 10'h1EB) == 8'h42, "R7", "target byte", rd(12'h286, 10'h1EB), 8'h42);
    chk(rd(12'h286, 10'h1EA) == (8'hEA ^ 8'h5A), "R7", "neighbour low",
        rd(12'h286, 10'h1EA), 8'hEA ^ 8'h5A);
    chk(rd(12'h286, 10'h20F) == (8'h0F ^ 8'h5A), "R7", "last byte kept",
        rd(12'h286, 10'h20F), 8'h0F ^ 8'h5A);
  endtask

  task automatic t_last_offset_528();
    logic seen;
    model_512 = 1'b0; busy_polls = 0; clear_log();
    pulse_start(0, 10'h20F, 8'h3C);
    wait_done(seen);
    chk(err == 1'b0, "R3", "offset 20F accepted", err, 0);
    check_sequence("528 edge", 0, 10'h20F, 8'h3C, 1'b0, 0);
    chk(rd(0, 10'h20F) == 8'h3C, "R7", "edge byte", rd(0, 10'h20F), 8'h3C);
    chk(rd(0, 10'h000) == 8'hFF, "R7", "erased byte kept", rd(0, 0), 8'hFF);
  endtask

  task automatic t_offset_err();
    logic seen;
    model_512 = 1'b0; busy_polls = 0; clear_log();
    pulse_start(12'h010, 10'h210, 8'h11);
    wait_done(seen);
    chk(err == 1'b1, "R3", "528 offset 210 rejected", err, 1);
    chk(nlog == 1 && op_l[0] == 8'hD7, "R3", "only status issued", nlog, 1);
    repeat (10) @(negedge clk);
    chk(err == 1'b1 && cs_n == 1'b1, "R3", "err held, deselected", err, 1);
    chk(rd(12'h010, 0) == 8'hFF, "R3", "page untouched", rd(12'h010, 0), 8'hFF);
    model_512 = 1'b1; clear_log();
    pulse_start(12'h020, 10'h200, 8'h22);
    wait_done(seen);
    chk(err == 1'b1, "R3", "512 offset 200 rejected", err, 1);
    chk(nlog == 1, "R2", "512 reject after mode read", nlog, 1);
  endtask

  task automatic t_update_512();
    logic seen;
    model_512 = 1'b1; busy_polls = 1; clear_log();
    fill_page(12'hFFF, 512);
    pulse_start(12'hFFF, 10'h1FF, 8'hA5);
    @(negedge clk);
    chk(err == 1'b0, "R3", "err cleared by new start", err, 0);
    wait_done(seen);
    chk(err == 1'b0, "R10", "512 success", err, 0);
    check_sequence("512", 12'hFFF, 10'h1FF, 8'hA5, 1'b1, 1);
    chk(rd(12'hFFF, 10'h1FF) == 8'hA5, "R7", "512 target", rd(12'hFFF, 10'h1FF), 8'hA5);
    chk(rd(12'hFFF, 10'h000) == 8'h5A, "R7", "512 first kept", rd(12'hFFF, 0), 8'h5A);
  endtask

  task automatic t_start_while_busy();
    logic seen;
    int n_cmd = 0;
    model_512 = 1'b0; busy_polls = 3; clear_log();
    pulse_start(12'h100, 10'h004, 8'h99);
    repeat (60) @(negedge clk);
    pulse_start(12'h001, 10'h005, 8'h77);
    wait_done(seen);
    for (int i = 0; i < nlog; i++) if (op_l[i] != 8'hD7) n_cmd++;
    chk(n_cmd == 3, "R1", "one operation only", n_cmd, 3);
    chk(rd(12'h100, 10'h004) == 8'h99, "R1", "first request done", rd(12'h100, 4), 8'h99);
    chk(rd(12'h001, 10'h005) == 8'hFF, "R1", "busy start ignored", rd(12'h001, 5), 8'hFF);
    repeat (20) @(negedge clk);
    chk(cs_n == 1'b1 && busy == 1'b0, "R8", "idle after end", cs_n, 1);
  endtask

  task automatic t_timing();
    chk(n_rise > 0 && bad_period == 0, "R9", "bit period", bad_period, 0);
    chk(bad_mosi == 0, "R9", "mosi steady while sck high", bad_mosi, 0);
    chk(min_gap >= DIV / 2, "R8", "deselect gap", min_gap, DIV / 2);
  endtask

  // ---------------- watchdog and main ----------------
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected done", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_update_528();
    t_last_offset_528();
    t_offset_err();
    t_update_512();
    t_start_while_busy();
    t_timing();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule